// File: doc/BRIEF.md
# Handshaked Shift-Register Byte Transfer Engine

This block is the device half of a three-line handshake that moves bytes between a host and a device through a shared 8-bit shift register. The host owns two lines, *in-progress* and *acknowledge*. The device owns one line, *request*. All three are active low.

On every host write to port B, the engine looks at the new line levels and at the shift-direction bit, and compares them with the levels of the previous write. In the host-to-device direction, each handshake step stores the shift-register byte in a receive buffer. In the device-to-host direction, each step hands the next queued reply byte to the shift register. When the host ends a frame, the engine reports the collected packet length. When the host is idle, request follows acknowledge. Every step also starts a fixed delay, and when it expires the engine emits a one-cycle shift-register interrupt pulse.

A packet decoder reads the received bytes through a read port. It queues replies through a write port and a length-load strobe.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset, `req_n_o` is 1. `sr_irq_o`, `sr_load_o` and `pkt_valid_o` are 0. The receive count, reply size and reply index are 0.
- R2: Port B encoding: bit 5 is in-progress and bit 4 is acknowledge; bit 3 of `portb_i` is ignored. While bit 5 is 0 and `sr_out_i` is 1, a write that changes {bit 4, bit 5} from the previous write stores `sr_i` at the next receive index, readable on `rx_rd_data_o`, and schedules an interrupt. A write that changes neither bit does nothing.
- R3: The receive buffer holds RX_DEPTH (16) bytes. A store step with the buffer full drops the byte and schedules no interrupt.
- R4: While bit 5 is 0, `sr_out_i` is 0 and reply bytes remain, a pair-changing write pulses `sr_load_o` with the next reply byte in order and schedules an interrupt. The step that consumes the last byte drives `req_n_o` to 1.
- R5: While bit 5 is 0 and `sr_out_i` is 0, a write with no reply bytes left loads nothing and schedules no interrupt.
- R6: With bit 5 at 1 in both the new and the previous write, a change of bit 4 copies its new level to `req_n_o` and schedules an interrupt.
- R7: A write with bit 5 at 1 after a write with bit 5 at 0 always schedules an interrupt. It pulses `pkt_valid_o` with `pkt_len_o` equal to the bytes collected, if that count is at least 1. It drives `req_n_o` to 0 if reply bytes remain.
- R8: Reporting a packet clears the receive index, so the next frame stores from index 0.
- R9: `sr_irq_o` is a one-cycle pulse, (CLK_HZ/1e6)*DELAY_US cycles after the scheduling edge. A new schedule before expiry restarts the delay.
- R10: `rpl_load_i` sets the reply size to `rpl_len_i` (capped at RPL_DEPTH), clears the reply index, schedules an interrupt and leaves `req_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| portb_wr_i | input | 1 | Host wrote port B this cycle |
| portb_i | input | 8 | Port B value written |
| sr_out_i | input | 1 | Shift direction, 1 = host to device |
| sr_i | input | 8 | Current shift-register byte |
| rx_rd_addr_i | input | AW | Receive buffer read address |
| rx_rd_data_o | output | 8 | Receive buffer read data |
| rpl_wr_i | input | 1 | Reply buffer write strobe |
| rpl_wr_addr_i | input | AW | Reply buffer write address |
| rpl_wr_data_i | input | 8 | Reply buffer write data |
| rpl_load_i | input | 1 | Commit a reply of `rpl_len_i` bytes |
| rpl_len_i | input | LEN_W | Reply length |
| req_n_o | output | 1 | Request line level, active low |
| sr_load_o | output | 1 | Load shift register with `sr_load_data_o` |
| sr_load_data_o | output | 8 | Reply byte for the shift register |
| sr_irq_o | output | 1 | Delayed shift-register interrupt pulse |
| pkt_valid_o | output | 1 | Host packet complete |
| pkt_len_o | output | LEN_W | Length of completed packet |

## Verification
A port B write sampled at clock edge N changes `req_n_o`, `sr_load_o` and `pkt_valid_o` in the cycle after edge N. `sr_irq_o` rises after edge N+D, where D is the delay in cycles. The bench's behavioural model advances at the same edges and uses the same register count, and every output is compared on the falling edge, midway between updates. This makes both the one-cycle strobe timing and the exact delay to the interrupt observable, including restarts caused by back-to-back steps.

// File: rtl/hsk_xfer_pkg.sv
package hsk_xfer_pkg;
  localparam int unsigned REQ_BIT = 3;
  localparam int unsigned ACK_BIT = 4;
  localparam int unsigned TIP_BIT = 5;

  typedef struct packed {
    logic store;
    logic fetch;
    logic sched;
    logic pkt;
    logic req_wr;
    logic req_val;
  } line_act_t;
endpackage

// File: rtl/hsk_byte_ram.sv
module hsk_byte_ram #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (wr_i && (wr_addr_i == AW'(g)))          mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = mem_q[i];
  end
endmodule

// File: rtl/hsk_line_ctl.sv
module hsk_line_ctl
  import hsk_xfer_pkg::*;
(
  input  logic      wr_i,
  input  logic      tip_i,
  input  logic      ack_i,
  input  logic      last_tip_i,
  input  logic      last_ack_i,
  input  logic      sr_out_i,
  input  logic      rx_room_i,
  input  logic      rx_nonempty_i,
  input  logic      rpl_pend_i,
  input  logic      rpl_last_i,
  output line_act_t act_o
);
  logic pair_chg;
  assign pair_chg = (tip_i != last_tip_i) || (ack_i != last_ack_i);

  always_comb begin
    act_o = '0;
    if (wr_i) begin
      if (!tip_i) begin
        // transfer active: one byte per pair change
        if (pair_chg) begin
          if (sr_out_i) begin
            if (rx_room_i) begin
              act_o.store = 1'b1;
              act_o.sched = 1'b1;
            end
          end else if (rpl_pend_i) begin
            act_o.fetch = 1'b1;
            act_o.sched = 1'b1;
            if (rpl_last_i) begin
              act_o.req_wr  = 1'b1;
              act_o.req_val = 1'b1;
            end
          end
        end
      end else if (last_tip_i && (ack_i != last_ack_i)) begin
        // idle sync: request mirrors acknowledge
        act_o.req_wr  = 1'b1;
        act_o.req_val = ack_i;
        act_o.sched   = 1'b1;
      end else if (!last_tip_i) begin
        // frame just ended
        act_o.sched = 1'b1;
        act_o.pkt   = rx_nonempty_i;
        if (rpl_pend_i) begin
          act_o.req_wr  = 1'b1;
          act_o.req_val = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hsk_sr_delay.sv
module hsk_sr_delay #(
  parameter int unsigned DELAY_CYC = 2000,
  localparam int unsigned DW = $clog2(DELAY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sched_i,
  output logic irq_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else if (sched_i) begin
      cnt_q <= DW'(DELAY_CYC);
      irq_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      irq_o <= (cnt_q == DW'(1));
    end else begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
  import hsk_xfer_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned DELAY_US  = 20,
  parameter int unsigned RX_DEPTH  = 16,
  parameter int unsigned RPL_DEPTH = 16,
  localparam int unsigned DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US,
  localparam int unsigned AW    = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1,
  localparam int unsigned RAW   = (RPL_DEPTH > 1) ? $clog2(RPL_DEPTH) : 1,
  localparam int unsigned LEN_W = $clog2(RX_DEPTH + 1),
  localparam int unsigned RLW   = $clog2(RPL_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             portb_wr_i,
  input  logic [7:0]       portb_i,
  input  logic             sr_out_i,
  input  logic [7:0]       sr_i,
  input  logic [AW-1:0]    rx_rd_addr_i,
  output logic [7:0]       rx_rd_data_o,
  input  logic             rpl_wr_i,
  input  logic [RAW-1:0]   rpl_wr_addr_i,
  input  logic [7:0]       rpl_wr_data_i,
  input  logic             rpl_load_i,
  input  logic [RLW-1:0]   rpl_len_i,
  output logic             req_n_o,
  output logic             sr_load_o,
  output logic [7:0]       sr_load_data_o,
  output logic             sr_irq_o,
  output logic             pkt_valid_o,
  output logic [LEN_W-1:0] pkt_len_o
);
  logic             last_tip_q, last_ack_q, req_q;
  logic [LEN_W-1:0] rx_idx_q;
  logic [RLW-1:0]   rpl_size_q, rpl_idx_q, eff_size, eff_idx, len_cap;
  logic [7:0]       rpl_rd_data;
  logic             rpl_pend, rpl_last;
  line_act_t        act;

  assign len_cap  = (rpl_len_i > RLW'(RPL_DEPTH)) ? RLW'(RPL_DEPTH) : rpl_len_i;
  assign eff_size = rpl_load_i ? len_cap : rpl_size_q;
  assign eff_idx  = rpl_load_i ? '0 : rpl_idx_q;
  assign rpl_pend = eff_idx < eff_size;
  assign rpl_last = (eff_idx + RLW'(1)) >= eff_size;

  hsk_line_ctl u_ctl (
    .wr_i         (portb_wr_i),
    .tip_i        (portb_i[TIP_BIT]),
    .ack_i        (portb_i[ACK_BIT]),
    .last_tip_i   (last_tip_q),
    .last_ack_i   (last_ack_q),
    .sr_out_i     (sr_out_i),
    .rx_room_i    (rx_idx_q < LEN_W'(RX_DEPTH)),
    .rx_nonempty_i(rx_idx_q != '0),
    .rpl_pend_i   (rpl_pend),
    .rpl_last_i   (rpl_last),
    .act_o        (act)
  );

  hsk_byte_ram #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (act.store),
    .wr_addr_i(rx_idx_q[AW-1:0]),
    .wr_data_i(sr_i),
    .rd_addr_i(rx_rd_addr_i),
    .rd_data_o(rx_rd_data_o)
  );

  hsk_byte_ram #(.DEPTH(RPL_DEPTH)) u_rpl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (rpl_wr_i),
    .wr_addr_i(rpl_wr_addr_i),
    .wr_data_i(rpl_wr_data_i),
    .rd_addr_i(eff_idx[RAW-1:0]),
    .rd_data_o(rpl_rd_data)
  );

  hsk_sr_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sched_i(act.sched | rpl_load_i),
    .irq_o  (sr_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_tip_q     <= 1'b1;
      last_ack_q     <= 1'b1;
      req_q          <= 1'b1;
      rx_idx_q       <= '0;
      rpl_size_q     <= '0;
      rpl_idx_q      <= '0;
      sr_load_o      <= 1'b0;
      sr_load_data_o <= '0;
      pkt_valid_o    <= 1'b0;
      pkt_len_o      <= '0;
    end else begin
      sr_load_o   <= act.fetch;
      pkt_valid_o <= act.pkt;
      if (portb_wr_i) begin
        last_tip_q <= portb_i[TIP_BIT];
        last_ack_q <= portb_i[ACK_BIT];
      end
      if (act.req_wr) req_q <= act.req_val;
      if (act.fetch)  sr_load_data_o <= rpl_rd_data;
      if (act.pkt) begin
        pkt_len_o <= rx_idx_q;
        rx_idx_q  <= '0;
      end else if (act.store) begin
        rx_idx_q  <= rx_idx_q + 1'b1;
      end
      rpl_size_q <= eff_size;
      rpl_idx_q  <= act.fetch ? eff_idx + 1'b1 : eff_idx;
    end
  end

  assign req_n_o = req_q;
endmodule

// File: rtl/hsk_xfer_chk.sv
module hsk_xfer_chk #(
  parameter int unsigned LEN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             portb_wr_i,
  input logic [7:0]       portb_i,
  input logic             req_n_o,
  input logic             sr_load_o,
  input logic             sr_irq_o,
  input logic             pkt_valid_o,
  input logic [LEN_W-1:0] pkt_len_o
);
  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_irq_o |=> !sr_irq_o);
  p_pkt_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !pkt_valid_o);
  p_pkt_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> pkt_len_o != '0);
  p_pkt_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> $past(portb_wr_i && portb_i[5]));
  p_load_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_o |-> $past(portb_wr_i && !portb_i[5]));
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !portb_wr_i |=> $stable(req_n_o));
endmodule

bind hsk_xfer_engine hsk_xfer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .portb_wr_i (portb_wr_i),
  .portb_i    (portb_i),
  .req_n_o    (req_n_o),
  .sr_load_o  (sr_load_o),
  .sr_irq_o   (sr_irq_o),
  .pkt_valid_o(pkt_valid_o),
  .pkt_len_o  (pkt_len_o)
);

// File: tb/hsk_xfer_engine_test.sv
`timescale 1ns/1ps
module hsk_xfer_engine_test;
  localparam int unsigned D = 20;  // CLK_HZ 1 MHz, 20 us

  logic       clk_i = 0, rst_ni = 0;
  logic       portb_wr_i = 0, sr_out_i = 0, rpl_wr_i = 0, rpl_load_i = 0;
  logic [7:0] portb_i = 8'h30, sr_i = 0, rpl_wr_data_i = 0;
  logic [3:0] rx_rd_addr_i = 0, rpl_wr_addr_i = 0;
  logic [4:0] rpl_len_i = 0;
  logic [7:0] rx_rd_data_o, sr_load_data_o;
  logic       req_n_o, sr_load_o, sr_irq_o, pkt_valid_o;
  logic [4:0] pkt_len_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  hsk_xfer_engine #(.CLK_HZ(1_000_000), .DELAY_US(20)) uut (.*);

  // behavioural reference model
  int   m_last_tip, m_last_ack, m_req, m_load, m_ld_data, m_irq, m_pkt, m_len, m_tmr;
  byte  rxq[$], frame[$];
  byte  rpl_mem[16];
  int   rpl_size, rpl_idx;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_last_tip = 1; m_last_ack = 1; m_req = 1; m_load = 0; m_ld_data = 0;
      m_irq = 0; m_pkt = 0; m_len = 0; m_tmr = 0; rxq.delete();
      rpl_size = 0; rpl_idx = 0;
      foreach (rpl_mem[i]) rpl_mem[i] = 0;
    end else begin
      bit sched;
      int tip, ack;
      sched = 0; m_load = 0; m_pkt = 0;
      if (rpl_load_i) begin
        rpl_size = (rpl_len_i > 16) ? 16 : rpl_len_i; rpl_idx = 0; sched = 1;
      end
      if (portb_wr_i) begin
        tip = portb_i[5]; ack = portb_i[4];
        if (tip == 0) begin
          if (tip != m_last_tip || ack != m_last_ack) begin
            if (sr_out_i) begin
              if (rxq.size() < 16) begin rxq.push_back(sr_i); sched = 1; end
            end else if (rpl_idx < rpl_size) begin
              m_load = 1; m_ld_data = rpl_mem[rpl_idx]; rpl_idx++; sched = 1;
              if (rpl_idx >= rpl_size) m_req = 1;
            end
          end
        end else if (m_last_tip == 1 && ack != m_last_ack) begin
          m_req = ack; sched = 1;
        end else if (m_last_tip == 0) begin
          sched = 1;
          if (rxq.size() > 0) begin
            m_pkt = 1; m_len = rxq.size(); frame = rxq; rxq.delete();
          end
          if (rpl_idx < rpl_size) m_req = 0;
        end
        m_last_tip = tip; m_last_ack = ack;
      end
      if (rpl_wr_i) rpl_mem[rpl_wr_addr_i] = rpl_wr_data_i;
      if (sched) begin m_tmr = D; m_irq = 0; end
      else if (m_tmr > 0) begin m_tmr--; m_irq = (m_tmr == 0); end
      else m_irq = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk("R6 req_n", req_n_o, m_req);
    chk("R4 sr_load", sr_load_o, m_load);
    if (m_load) chk("R4 load data", sr_load_data_o, m_ld_data & 8'hff);
    chk("R9 irq", sr_irq_o, m_irq);
    chk("R7 pkt_valid", pkt_valid_o, m_pkt);
    if (m_pkt) chk("R7 pkt_len", pkt_len_o, m_len);
  end

  task automatic wr_b(int tip, int ack, logic [7:0] sr, int gap);
    @(negedge clk_i);
    portb_i = {2'b00, tip[0], ack[0], 4'h8}; // bit3 set: must be ignored
    sr_i = sr; portb_wr_i = 1;
    @(negedge clk_i);
    portb_wr_i = 0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic load_reply(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      rpl_wr_i = 1; rpl_wr_addr_i = 4'(i); rpl_wr_data_i = base + 8'(i);
    end
    @(negedge clk_i);
    rpl_wr_i = 0; rpl_load_i = 1; rpl_len_i = 5'(len);
    @(negedge clk_i);
    rpl_load_i = 0;
  endtask

  task automatic check_frame(string tag);
    for (int i = 0; i < frame.size(); i++) begin
      rx_rd_addr_i = 4'(i);
      #1 chk(tag, rx_rd_data_o, frame[i] & 8'hff);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 req_n reset", req_n_o, 1);
    chk("R1 irq reset", sr_irq_o, 0);
    chk("R1 pkt reset", pkt_valid_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R2/R8: host sends three bytes, packet reported
    sr_out_i = 1;
    wr_b(0, 1, 8'hA1, D + 3);
    wr_b(0, 1, 8'hEE, 3);           // R2: no pair change, ignored
    wr_b(0, 0, 8'hB2, D + 3);
    wr_b(0, 1, 8'hC3, D + 3);
    wr_b(1, 1, 8'h00, D + 3);       // R7: frame end
    check_frame("R2 rx data");

    // R6: idle sync, request mirrors acknowledge
    wr_b(1, 0, 8'h00, D + 3);
    wr_b(1, 1, 8'h00, D + 3);

    // R10/R4: reply of 2 bytes read by host
    load_reply(2, 8'h50);
    repeat (D + 3) @(negedge clk_i);
    sr_out_i = 0;
    wr_b(0, 1, 8'h00, D + 3);
    wr_b(0, 0, 8'h00, D + 3);
    wr_b(0, 1, 8'h00, D + 3);       // R5: none left
    wr_b(1, 1, 8'h00, D + 3);       // R7: empty frame, irq only

    // R7: frame end with reply pending asserts request
    load_reply(3, 8'h70);
    sr_out_i = 1;
    wr_b(0, 1, 8'h11, 4);
    wr_b(1, 1, 8'h00, D + 3);
    check_frame("R8 rx restart");
    sr_out_i = 0;
    for (int i = 0; i < 3; i++) wr_b(0, i % 2, 8'h00, 3);
    wr_b(1, 1, 8'h00, D + 3);

    // R3/R9: overflow with back-to-back steps restarting the delay
    sr_out_i = 1;
    for (int i = 0; i < 18; i++) wr_b(0, i % 2, 8'(8'h20 + i), 2);
    repeat (D + 3) @(negedge clk_i);
    wr_b(1, 1, 8'h00, D + 3);
    check_frame("R3 full frame");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule